// File: doc/BRIEF.md
# Offset Register Sequential Loader

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic. Each offset is sixteen bits wide and is held as two byte registers, four registers in all. Software-facing logic loads them through the ordinary data input of the FIFO. It holds the load strobe low and uses the write enable, and each write-clock edge stores one byte. An internal pointer chooses the byte register and steps through them in a fixed rotating order.

Readback uses the same strobe together with the two read enables. On each read-clock edge one register is copied into the registered output. A second, independent pointer chooses that register and walks the same rotating order.

Either pointer stops wherever a load or readback burst ends, and the next burst picks up at the following register. Both offsets are combined and masked to the FIFO address width before they are sent to the flag comparators. The write and read clocks may be unrelated or the same clock.

Top module: `ofs_loader`

## Requirements
- R1: When `loadN` and `wrEn1N` are both 0 at a rising `wrClk`, the low 8 bits of `dataIn` are stored into the register that the write pointer selects, and the pointer advances by one.
- R2: The write pointer visits the registers in a fixed order: index 0 is the empty-offset low byte, index 1 the empty-offset high byte, index 2 the full-offset low byte and index 3 the full-offset high byte. The fifth load wraps back to index 0.
- R3: When `loadN` is 1, or `wrEn1N` is 1, at a write edge, no register changes and the write pointer keeps its position. A later load continues with the next register in the sequence.
- R4: When `loadN`, `rdEn1N` and `rdEn2N` are all 0 at a rising `rdClk`, the register selected by the readback pointer is copied into `dataOut`. In every other case `dataOut` holds its value.
- R5: The readback pointer follows the same order as the write pointer, advances once per readback, wraps after index 3, and is independent of the write pointer.
- R6: While `rstN` is 0, both offsets return to 7 (low bytes 0x07, high bytes 0x00), both pointers return to index 0 and `dataOut` is cleared to zero.
- R7: Bit 8 of `dataIn` is ignored on load. Bit 8 of `dataOut` is always 0.
- R8: `emptyOffset` is {index1, index0} and `fullOffset` is {index3, index2}, each with every bit at or above `ADDR_W` (default 12) forced to 0.
- R9: When a load and a readback fall on the same edge and address the same register, the readback returns the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock; loads happen on its rising edge |
| rdClk | input | 1 | Read clock; readbacks happen on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn1N | input | 1 | Active-low write enable |
| loadN | input | 1 | Active-low load/readback mode strobe |
| rdEn1N | input | 1 | First active-low read enable |
| rdEn2N | input | 1 | Second active-low read enable |
| dataIn | input | 9 | Data input; the low byte is loaded |
| dataOut | output | 9 | Registered readback data |
| emptyOffset | output | 16 | Masked empty offset sent to the flag logic |
| fullOffset | output | 16 | Masked full offset sent to the flag logic |

## Verification
A load and a readback can land on the same clock edge. The bench drives one clock into both clock ports to provoke this, and places both pointers on the empty-offset high byte before asserting write and readback together. It judges the outcome by requiring `dataOut` to carry the byte held before that edge while `emptyOffset` already shows the new byte. Both pointers must then keep stepping independently.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  localparam int REG_CNT = 4;
  localparam int PTR_W   = $clog2(REG_CNT);

  // Register indices; the walk order is behavioural
  typedef enum logic [PTR_W-1:0] {
    SEL_EMPTY_LO = 2'd0,
    SEL_EMPTY_HI = 2'd1,
    SEL_FULL_LO  = 2'd2,
    SEL_FULL_HI  = 2'd3
  } ofs_sel_e;

  typedef struct packed {
    logic     wrStb;
    ofs_sel_e wrSel;
    logic     rdStb;
    ofs_sel_e rdSel;
  } ofs_strobe_t;

  function automatic ofs_sel_e nextSel(input ofs_sel_e cur);
    return ofs_sel_e'(PTR_W'(cur) + PTR_W'(1));
  endfunction

endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
(
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        wrEn1N,
  input  logic        loadN,
  input  logic        rdEn1N,
  input  logic        rdEn2N,
  output ofs_strobe_t strobes
);

  ofs_sel_e wrPtr;
  ofs_sel_e rdPtr;
  logic     loadHit;
  logic     readHit;

  assign loadHit = ~loadN & ~wrEn1N;
  assign readHit = ~loadN & ~rdEn1N & ~rdEn2N;

  // Write pointer lives in the write clock domain
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= SEL_EMPTY_LO;
    end else if (loadHit) begin
      wrPtr <= nextSel(wrPtr);
    end
  end

  // Readback pointer lives in the read clock domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= SEL_EMPTY_LO;
    end else if (readHit) begin
      rdPtr <= nextSel(rdPtr);
    end
  end

  always_comb begin
    strobes.wrStb = loadHit;
    strobes.wrSel = wrPtr;
    strobes.rdStb = readHit;
    strobes.rdSel = rdPtr;
  end

endmodule

// File: rtl/ofs_dpath.sv
module ofs_dpath
  import ofs_pkg::*;
#(
  parameter int                  DATA_W    = 9,
  parameter int                  BYTE_W    = 8,
  parameter int                  ADDR_W    = 12,
  parameter logic [2*BYTE_W-1:0] EMPTY_DEF = 16'd7,
  parameter logic [2*BYTE_W-1:0] FULL_DEF  = 16'd7
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  ofs_strobe_t         strobes,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic [2*BYTE_W-1:0] emptyOffset,
  output logic [2*BYTE_W-1:0] fullOffset
);

  localparam int OFS_W = 2 * BYTE_W;
  localparam int PAD_W = DATA_W - BYTE_W;
  localparam logic [OFS_W-1:0] OFS_MASK =
    (ADDR_W >= OFS_W) ? {OFS_W{1'b1}} : OFS_W'((64'd1 << ADDR_W) - 64'd1);

  logic [BYTE_W-1:0] ofsReg [REG_CNT];
  logic [PAD_W-1:0]  unusedHiBits;

  assign unusedHiBits = dataIn[DATA_W-1:BYTE_W];

  for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_reg
    localparam logic [OFS_W-1:0]  SRC = (gi < 2) ? EMPTY_DEF : FULL_DEF;
    localparam logic [BYTE_W-1:0] DEF = (gi % 2 == 0) ? SRC[BYTE_W-1:0]
                                                      : SRC[OFS_W-1:BYTE_W];
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN) begin
        ofsReg[gi] <= DEF;
      end else if (strobes.wrStb && (strobes.wrSel == ofs_sel_e'(gi))) begin
        ofsReg[gi] <= dataIn[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobes.rdStb) begin
      dataOut <= {{PAD_W{1'b0}}, ofsReg[strobes.rdSel]};
    end
  end

  assign emptyOffset = {ofsReg[SEL_EMPTY_HI], ofsReg[SEL_EMPTY_LO]} & OFS_MASK;
  assign fullOffset  = {ofsReg[SEL_FULL_HI],  ofsReg[SEL_FULL_LO]}  & OFS_MASK;

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int                  DATA_W    = 9,
  parameter int                  BYTE_W    = 8,
  parameter int                  ADDR_W    = 12,
  parameter logic [2*BYTE_W-1:0] EMPTY_DEF = 16'd7,
  parameter logic [2*BYTE_W-1:0] FULL_DEF  = 16'd7
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  logic                wrEn1N,
  input  logic                loadN,
  input  logic                rdEn1N,
  input  logic                rdEn2N,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic [2*BYTE_W-1:0] emptyOffset,
  output logic [2*BYTE_W-1:0] fullOffset
);

  ofs_strobe_t strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  ofs_ctrl u_ctrl (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .rstN   (rstN),
    .wrEn1N (wrEn1N),
    .loadN  (loadN),
    .rdEn1N (rdEn1N),
    .rdEn2N (rdEn2N),
    .strobes(strobes)
  );

  ofs_dpath #(
    .DATA_W   (DATA_W),
    .BYTE_W   (BYTE_W),
    .ADDR_W   (ADDR_W),
    .EMPTY_DEF(EMPTY_DEF),
    .FULL_DEF (FULL_DEF)
  ) u_dpath (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .emptyOffset(emptyOffset),
    .fullOffset (fullOffset)
  );

  assign wrPtr = strobes.wrSel;
  assign rdPtr = strobes.rdSel;

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk
  import ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 12
) (
  input logic                wrClk,
  input logic                rdClk,
  input logic                rstN,
  input logic                wrEn1N,
  input logic                loadN,
  input logic                rdEn1N,
  input logic                rdEn2N,
  input logic [DATA_W-1:0]   dataOut,
  input logic [2*BYTE_W-1:0] emptyOffset,
  input logic [2*BYTE_W-1:0] fullOffset,
  input logic [PTR_W-1:0]    wrPtr,
  input logic [PTR_W-1:0]    rdPtr
);

  localparam int OFS_W = 2 * BYTE_W;
  localparam logic [OFS_W-1:0] HI_BITS =
    (ADDR_W >= OFS_W) ? '0 : ~OFS_W'((64'd1 << ADDR_W) - 64'd1);

  p_wr_step_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    (!loadN && !wrEn1N) |=> (wrPtr == PTR_W'($past(wrPtr) + 1'b1)));

  p_wr_hold_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    !(!loadN && !wrEn1N) |=> ($stable(wrPtr) && $stable(emptyOffset) && $stable(fullOffset)));

  p_rd_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    !(!loadN && !rdEn1N && !rdEn2N) |=> $stable(dataOut));

  p_rd_step_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!loadN && !rdEn1N && !rdEn2N) |=> (rdPtr == PTR_W'($past(rdPtr) + 1'b1)));

  p_pad_zero_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    dataOut[DATA_W-1:BYTE_W] == '0);

  p_masked_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    ((emptyOffset | fullOffset) & HI_BITS) == '0);

endmodule

bind ofs_loader ofs_loader_chk #(
  .DATA_W(DATA_W),
  .BYTE_W(BYTE_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .wrClk      (wrClk),
  .rdClk      (rdClk),
  .rstN       (rstN),
  .wrEn1N     (wrEn1N),
  .loadN      (loadN),
  .rdEn1N     (rdEn1N),
  .rdEn2N     (rdEn2N),
  .dataOut    (dataOut),
  .emptyOffset(emptyOffset),
  .fullOffset (fullOffset),
  .wrPtr      (wrPtr),
  .rdPtr      (rdPtr)
);

// File: tb/ofs_loader_bench.sv
module ofs_loader_bench;

  localparam time CLK_P = 5ns;

  typedef struct packed {
    logic        loadN;
    logic        wrN;
    logic        rd1N;
    logic        rd2N;
    logic [8:0]  din;
    logic [8:0]  expOut;
    logic [15:0] expE;
    logic [15:0] expF;
    logic [3:0]  req;
  } vec_t;

  // Both clock ports share one clock, so same-edge cases can be forced
  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b1,1'b1,1'b1, 9'h1AB, 9'h000, 16'h0007, 16'h0007, 4'd6}, // R6 idle after reset
    '{1'b0,1'b0,1'b1,1'b1, 9'h1A5, 9'h000, 16'h00A5, 16'h0007, 4'd7}, // R1 R7 load idx0, bit 8 dropped
    '{1'b0,1'b0,1'b1,1'b1, 9'h03C, 9'h000, 16'h0CA5, 16'h0007, 4'd8}, // R8 idx1, masked to 12 bits
    '{1'b1,1'b0,1'b1,1'b1, 9'h0FF, 9'h000, 16'h0CA5, 16'h0007, 4'd3}, // R3 strobe high: no load
    '{1'b0,1'b1,1'b1,1'b1, 9'h055, 9'h000, 16'h0CA5, 16'h0007, 4'd3}, // R3 write enable high: no load
    '{1'b0,1'b0,1'b1,1'b1, 9'h012, 9'h000, 16'h0CA5, 16'h0012, 4'd2}, // R2 resumes at idx2
    '{1'b0,1'b0,1'b1,1'b1, 9'h0F4, 9'h000, 16'h0CA5, 16'h0412, 4'd8}, // R8 idx3, masked
    '{1'b0,1'b0,1'b1,1'b1, 9'h066, 9'h000, 16'h0C66, 16'h0412, 4'd2}, // R2 fifth load wraps to idx0
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 9'h066, 16'h0C66, 16'h0412, 4'd4}, // R4 readback idx0
    '{1'b0,1'b1,1'b0,1'b1, 9'h000, 9'h066, 16'h0C66, 16'h0412, 4'd4}, // R4 one read enable high: hold
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 9'h03C, 16'h0C66, 16'h0412, 4'd5}, // R5 idx1
    '{1'b1,1'b1,1'b0,1'b0, 9'h000, 9'h03C, 16'h0C66, 16'h0412, 4'd4}, // R4 strobe high: hold
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 9'h012, 16'h0C66, 16'h0412, 4'd5}, // R5 idx2
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 9'h0F4, 16'h0C66, 16'h0412, 4'd5}, // R5 idx3
    '{1'b0,1'b1,1'b0,1'b0, 9'h000, 9'h066, 16'h0C66, 16'h0412, 4'd5}, // R5 wraps to idx0
    '{1'b0,1'b0,1'b0,1'b0, 9'h099, 9'h03C, 16'h0966, 16'h0412, 4'd9}, // R9 same-edge idx1: old byte out
    '{1'b1,1'b1,1'b1,1'b1, 9'h000, 9'h03C, 16'h0966, 16'h0412, 4'd9}  // R9 settled values
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn1N, loadN, rdEn1N, rdEn2N;
  logic [8:0]  dataIn;
  logic [8:0]  dataOut;
  logic [15:0] emptyOffset, fullOffset;
  int          nChecks = 0;
  int          nFails  = 0;

  always #(CLK_P / 2) clk = ~clk;

  ofs_loader u_ofs_loader (
    .wrClk      (clk),
    .rdClk      (clk),
    .rstN       (rstN),
    .wrEn1N     (wrEn1N),
    .loadN      (loadN),
    .rdEn1N     (rdEn1N),
    .rdEn2N     (rdEn2N),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .emptyOffset(emptyOffset),
    .fullOffset (fullOffset)
  );

  task automatic check(input string tag, input logic [8:0] eo,
                       input logic [15:0] ee, input logic [15:0] ef);
    nChecks++;
    if (dataOut !== eo || emptyOffset !== ee || fullOffset !== ef) begin
      nFails++;
      $display("FAIL %s: out=%h E=%h F=%h expected out=%h E=%h F=%h",
               tag, dataOut, emptyOffset, fullOffset, eo, ee, ef);
    end
  endtask

  task automatic drive(input logic l, input logic w, input logic r1,
                       input logic r2, input logic [8:0] d);
    loadN = l; wrEn1N = w; rdEn1N = r1; rdEn2N = r2; dataIn = d;
  endtask

  initial begin
    #(CLK_P * 100000);
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
    repeat (3) @(negedge clk);
    check("R6 reset state", 9'h000, 16'h0007, 16'h0007);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].loadN, VECS[i].wrN, VECS[i].rd1N, VECS[i].rd2N, VECS[i].din);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].expOut, VECS[i].expE, VECS[i].expF);
    end

    // R6: a reset in mid-sequence restores defaults and both pointers
    drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
    rstN = 1'b0;
    @(negedge clk);
    check("R6 mid-run reset", 9'h000, 16'h0007, 16'h0007);
    rstN = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h011);
    @(negedge clk);
    check("R6 write pointer back at idx0", 9'h000, 16'h0011, 16'h0007);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    @(negedge clk);
    check("R6 readback pointer back at idx0", 9'h011, 16'h0011, 16'h0007);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
    @(negedge clk);
    check("R4 idle hold after readback", 9'h011, 16'h0011, 16'h0007);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule